// File: doc/BRIEF.md
# Page Migration Reference Counter Unit

This unit sits beside the directory of a home memory node. For each page it tracks, it keeps one saturating reference counter per node. Every access event brings a page index and the ID of the node that made the access. The unit adds one to that node's counter for that page. When the access comes from a remote node, the unit compares the remote node's new count with the home node's count for the same page.

When the remote count exceeds the home count by more than a programmable margin, the unit raises a migration interrupt. The interrupt carries the page index and the node that should receive the page. Only one interrupt is outstanding at a time. An acknowledge from software closes it and clears every counter of the named page, because that page has now migrated. A separate clear command zeroes all counters of any chosen page. Decisions are made in hardware, so software takes part only after the interrupt.

Top module: `page_mig_ctr`

## Requirements
- R1: After reset every counter is zero and `irq_valid` is low.
- R2: An accepted access adds one to the counter of the given node for the given page and changes no other counter.
- R3: Accesses from node `HOME_NODE` (default 0) count toward the home counter and never raise an interrupt.
- R4: A remote access whose incremented count is strictly greater than the page's home count plus `thresh` raises `irq_valid` on the next clock edge, with `irq_page` and `irq_node` equal to that access's page and node.
- R5: A counter saturates at 2^CNT_W-1 (15 by default) and never wraps.
- R6: `clr_valid` zeroes all counters of `clr_page` on the next edge. An access to the same page in the same cycle is discarded.
- R7: `irq_ack` while `irq_valid` is high drops `irq_valid` on the next edge and zeroes all counters of `irq_page`. An access to that page in the same cycle is discarded.
- R8: While an interrupt is outstanding, `irq_page` and `irq_node` hold and no new interrupt is raised. Counting continues, and a trigger during this time is dropped, not queued.
- R9: Counters are kept per page, so accesses to one page never move another page toward migration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access event present |
| acc_page | input | PG_W | Page index of the access |
| acc_node | input | NODE_W | Node ID of the requester |
| clr_valid | input | 1 | Clear all counters of a page |
| clr_page | input | PG_W | Page to clear |
| thresh | input | CNT_W | Margin by which the requester must lead the home count |
| irq_ack | input | 1 | Software acknowledge of the outstanding interrupt |
| irq_valid | output | 1 | Migration interrupt outstanding |
| irq_page | output | PG_W | Page to migrate |
| irq_node | output | NODE_W | Target node for the page |

## Verification
The counters can only be seen through the timing of interrupts. A wrong count, a missed clear or a wrapped counter therefore shows up as an interrupt that arrives one access too early, too late or not at all, or as one that names the wrong page or node. A bench model therefore replays every access and compares the interrupt outputs on every cycle. Directed runs drive counts right up to the threshold edge, past saturation, and into same-cycle clear and access collisions. This puts any error on the ports within one cycle of the access that exposes it.

// File: rtl/page_mig_ctr.sv
module page_mig_ctr #(
  parameter int PAGES     = 8,
  parameter int NODE_W    = 2,
  parameter int CNT_W     = 4,
  parameter int HOME_NODE = 0,
  localparam int PG_W     = $clog2(PAGES),
  localparam int NODES    = 1 << NODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PG_W-1:0]   acc_page,
  input  logic [NODE_W-1:0] acc_node,
  input  logic              clr_valid,
  input  logic [PG_W-1:0]   clr_page,
  input  logic [CNT_W-1:0]  thresh,
  input  logic              irq_ack,
  output logic              irq_valid,
  output logic [PG_W-1:0]   irq_page,
  output logic [NODE_W-1:0] irq_node
);
  localparam logic [NODE_W-1:0] HOME = NODE_W'(HOME_NODE);

  logic [CNT_W-1:0] cnt [PAGES][NODES];

  wire [CNT_W-1:0] cur    = cnt[acc_page][acc_node];
  wire [CNT_W-1:0] home_c = cnt[acc_page][HOME];
  wire [CNT_W-1:0] nxt    = (&cur) ? cur : cur + 1'b1;
  wire             ack_go = irq_valid && irq_ack;
  wire             hit    = (clr_valid && clr_page == acc_page) ||
                            (ack_go && irq_page == acc_page);
  wire             bump   = acc_valid && !hit;
  wire [CNT_W:0]   bar    = {1'b0, home_c} + {1'b0, thresh};
  wire             fire   = bump && (acc_node != HOME) && !irq_valid &&
                            ({1'b0, nxt} > bar);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++)
        for (int n = 0; n < NODES; n++)
          cnt[p][n] <= '0;
    end else begin
      for (int p = 0; p < PAGES; p++)
        for (int n = 0; n < NODES; n++)
          if ((clr_valid && clr_page == PG_W'(p)) || (ack_go && irq_page == PG_W'(p)))
            cnt[p][n] <= '0;
          else if (bump && acc_page == PG_W'(p) && acc_node == NODE_W'(n))
            cnt[p][n] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_page  <= '0;
      irq_node  <= '0;
    end else if (fire) begin
      irq_valid <= 1'b1;
      irq_page  <= acc_page;
      irq_node  <= acc_node;
    end else if (irq_ack) begin
      irq_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/page_mig_ctr_chk.sv
module page_mig_ctr_chk #(
  parameter int PG_W      = 3,
  parameter int NODE_W    = 2,
  parameter int HOME_NODE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [PG_W-1:0]   acc_page,
  input logic [NODE_W-1:0] acc_node,
  input logic              clr_valid,
  input logic [PG_W-1:0]   clr_page,
  input logic              irq_ack,
  input logic              irq_valid,
  input logic [PG_W-1:0]   irq_page,
  input logic [NODE_W-1:0] irq_node
);
  localparam logic [NODE_W-1:0] HOME = NODE_W'(HOME_NODE);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_page) && $stable(irq_node));

  p_remote_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_node != HOME);

  p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(acc_valid) && $past(acc_node) != HOME &&
                         $past(acc_page) == irq_page && $past(acc_node) == irq_node);

  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> !irq_valid);

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid && acc_valid && clr_valid && clr_page == acc_page |=> !irq_valid);
endmodule

bind page_mig_ctr page_mig_ctr_chk #(.PG_W(PG_W), .NODE_W(NODE_W), .HOME_NODE(HOME_NODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
  .acc_node(acc_node), .clr_valid(clr_valid), .clr_page(clr_page),
  .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_page(irq_page), .irq_node(irq_node)
);

// File: tb/test_page_mig_ctr.sv
`timescale 1ns/1ps
module test_page_mig_ctr;
  localparam int PAGES = 8, NODE_W = 2, CNT_W = 4, HOME = 0;
  localparam int PG_W = 3, NODES = 4, MAXC = 15;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, clr_valid = 0, irq_ack = 0;
  logic [PG_W-1:0] acc_page = 0, clr_page = 0;
  logic [NODE_W-1:0] acc_node = 0;
  logic [CNT_W-1:0] thresh = 0;
  logic irq_valid;
  logic [PG_W-1:0] irq_page;
  logic [NODE_W-1:0] irq_node;

  int n_chk = 0, n_fail = 0;
  int m_cnt [PAGES][NODES];
  bit m_irq;
  int m_pg, m_nd;

  always #5 clk = ~clk;

  page_mig_ctr i_page_mig_ctr (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
    .acc_node(acc_node), .clr_valid(clr_valid), .clr_page(clr_page),
    .thresh(thresh), .irq_ack(irq_ack), .irq_valid(irq_valid),
    .irq_page(irq_page), .irq_node(irq_node)
  );

  function automatic int sat_inc(int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  task automatic check(string tag);
    bit ok;
    n_chk++;
    ok = (irq_valid == m_irq) && (!m_irq || (irq_page == m_pg && irq_node == m_nd));
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: irq=%0d page=%0d node=%0d expected irq=%0d page=%0d node=%0d",
               tag, irq_valid, irq_page, irq_node, m_irq, m_pg, m_nd);
    end
  endtask

  task automatic step(bit av, int ap, int an, bit cv, int cp, bit ack, string tag);
    bit hit, trig;
    int nv;
    acc_valid = av; acc_page = PG_W'(ap); acc_node = NODE_W'(an);
    clr_valid = cv; clr_page = PG_W'(cp); irq_ack = ack;
    hit = (cv && cp == ap) || (m_irq && ack && m_pg == ap);
    trig = 0;
    if (av && !hit) begin
      nv = sat_inc(m_cnt[ap][an]);
      if (an != HOME && !m_irq && nv > m_cnt[ap][HOME] + int'(thresh)) trig = 1;
      m_cnt[ap][an] = nv;
    end
    if (cv) for (int n = 0; n < NODES; n++) m_cnt[cp][n] = 0;
    if (m_irq && ack) begin
      for (int n = 0; n < NODES; n++) m_cnt[m_pg][n] = 0;
      m_irq = 0;
    end
    if (trig) begin m_irq = 1; m_pg = ap; m_nd = an; end
    @(negedge clk);
    check(tag);
  endtask

  task automatic acc(int p, int n, string tag);
    step(1, p, n, 0, 0, 0, tag);
  endtask

  task automatic ack_it(string tag);
    step(0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    for (int p = 0; p < PAGES; p++) for (int n = 0; n < NODES; n++) m_cnt[p][n] = 0;
    m_irq = 0; m_pg = 0; m_nd = 0;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state");

    thresh = 2;
    acc(3, 2, "R2 first count");
    acc(3, 2, "R2 second count");
    acc(3, 2, "R4 lead past margin");
    n_chk++;
    if (!(irq_valid && irq_page == 3 && irq_node == 2)) begin
      n_fail++;
      $display("FAIL R4 payload: irq=%0d page=%0d node=%0d expected 1/3/2", irq_valid, irq_page, irq_node);
    end
    for (int i = 0; i < 4; i++) acc(5, 1, "R8 no second interrupt");
    ack_it("R7 ack drops interrupt");
    acc(3, 2, "R7 page cleared 1");
    acc(3, 2, "R7 page cleared 2");
    acc(3, 2, "R7 retrigger");
    ack_it("R7 ack");

    for (int i = 0; i < 5; i++) acc(1, HOME, "R3 home counts no irq");
    for (int i = 0; i < 8; i++) acc(1, 1, "R3 remote against home count");
    ack_it("R3 ack");

    thresh = 0;
    for (int i = 0; i < 20; i++) acc(2, HOME, "R5 home saturates");
    for (int i = 0; i < 18; i++) acc(2, 3, "R5 remote saturates, no irq");
    step(0, 0, 0, 1, 2, 0, "R6 clear page");
    acc(2, 3, "R6 count restarts after clear");
    ack_it("R6 ack");

    step(1, 4, 1, 1, 4, 0, "R6 clear beats access");
    acc(4, 1, "R6 access after clear");
    step(1, 4, 1, 0, 0, 1, "R7 ack beats same-page access");
    acc(4, 2, "R7 page zero after ack");
    ack_it("R7 ack");

    thresh = 1;
    acc(6, 1, "R9 page 6 one");
    acc(7, 1, "R9 page 7 one");
    acc(7, 2, "R9 page 7 other node");
    acc(6, 1, "R9 page 6 fires alone");
    ack_it("R9 ack");
    for (int p = 0; p < PAGES; p++) step(0, 0, 0, 1, p, 0, "R6 wipe");

    for (int i = 0; i < 4000; i++) begin
      bit av, cv, ak;
      int ap, an, cp;
      if ($urandom_range(0, 49) == 0) thresh = CNT_W'($urandom_range(0, 6));
      av = $urandom_range(0, 9) < 7;
      ap = $urandom_range(0, PAGES - 1);
      an = ($urandom_range(0, 3) == 0) ? HOME : $urandom_range(1, NODES - 1);
      cv = $urandom_range(0, 19) == 0;
      cp = $urandom_range(0, PAGES - 1);
      ak = m_irq && ($urandom_range(0, 4) == 0);
      step(av, ap, an, cv, cp, ak, "R2 R4 R8 random traffic");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule